// File: doc/BRIEF.md
# Root Port Interrupt Collector

This block gathers the interrupt events of one PCIe root port and folds them into a single interrupt line toward the host processor. There are two kinds of event. Four legacy INTx wires (A to D) each set a sticky bit in a summary register on their rising edge. Inbound MSI writes arrive on a plain write port as an address and data pair. A write counts as an MSI only when its address equals a programmable target address. It then sets one bit of a 32-entry vector status word, and that word reports upward through one MSI summary bit.

Software reaches the block through a simple 32-bit register port: a write strobe, a read strobe, a byte offset and write data, with read data returned one cycle later. A mask register uses the same bit positions as the summary register. The interrupt output is the registered OR of the summary bits that are not masked. To service MSIs, software clears the vector bits it has handled and reads the vector word until it returns zero. Only then does it clear the MSI summary bit. Writes that are dropped raise sticky error flags.

Top module: `rp_irq_collector`

Register map (byte offsets): 0x00 summary, 0x04 mask, 0x08 MSI vector status, 0x0C MSI target address, 0x10 error flags. Reads of any other offset return zero.

## Requirements
- R1: After reset the summary, vector and error registers read 0, the target address reads 0, the mask reads 0x008F0000 (every source masked), and irq_out is 0.
- R2: A rising edge on intx_in[i] sets summary bit 16+i. A level held high sets the bit only once, so after a write-one clear it stays clear until the input falls and rises again. Writing 1 to summary bits 19:16 clears them, and writing 0 leaves them unchanged.
- R3: An MSI write whose address equals the target register and whose data value d is below 32 sets vector bit d. It also sets summary bit 23 in the same clock edge.
- R4: An MSI write to any other address changes no vector bit and sets error bit 0. An MSI write to the matching address with a data value of 32 or more changes no vector bit and sets error bit 1.
- R5: Writing 1 to a bit of the vector register clears that bit. Bits written with 0 keep their value.
- R6: Summary bit 23 is set whenever any vector bit is set. A write-one clear of bit 23 has no effect while any vector bit is still set. Once set, the bit remains set after the vectors are cleared, until it is cleared explicitly.
- R7: The mask register holds masks at bits 23 and 19:16. A set mask bit blocks the matching summary bit. irq_out equals the OR of the unmasked summary bits, delayed by one clock.
- R8: When a set event and a write-one clear hit the same summary or vector bit in the same cycle, the bit ends up set.
- R9: Bits outside the defined fields read as 0, even after a write of all ones. A read returns data one clock after the read strobe. Unmapped offsets read 0.
- R10: The error flags are sticky and are cleared by writing 1 to them at offset 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_in | input | 4 | Legacy INTx A..D event inputs, level or pulse |
| msi_valid | input | 1 | Inbound MSI write strobe |
| msi_addr | input | 32 | Inbound MSI write address |
| msi_data | input | 32 | Inbound MSI write data (vector number) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd_en |
| irq_out | output | 1 | Interrupt to the host |

## Verification
Event arrival and software clearing can land on the same bit in the same cycle. A rising INTx edge can meet a write-one clear of its summary bit, and an MSI to vector k can meet a clear of vector bit k. The bench first sets the bit, then drives the new event and the clear in one cycle, and reads the register back; the bit must still be set. A second collision comes from the service protocol: a clear of the MSI summary bit while vectors remain pending must not take effect.

// File: rtl/rp_irq_pkg.sv
package rp_irq_pkg;

  // Field positions inside the summary and mask words
  localparam int unsigned INTX_LSB    = 16;
  localparam int unsigned MSI_SUM_BIT = 23;

  // Register byte offsets
  localparam int unsigned OFF_SUMMARY = 'h00;
  localparam int unsigned OFF_MASK    = 'h04;
  localparam int unsigned OFF_VECTOR  = 'h08;
  localparam int unsigned OFF_TARGET  = 'h0C;
  localparam int unsigned OFF_ERROR   = 'h10;

  // Error flag positions
  localparam int unsigned ERR_ADDR_BIT  = 0;
  localparam int unsigned ERR_RANGE_BIT = 1;
  localparam int unsigned ERR_W         = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SUMMARY,
    SEL_MASK,
    SEL_VECTOR,
    SEL_TARGET,
    SEL_ERROR
  } reg_sel_e;

endpackage

// File: rtl/rp_sticky_bits.sv
module rp_sticky_bits #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] bits_q;

  // A set in the same cycle as a clear leaves the bit set
  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
    end else begin
      bits_q <= (bits_q & ~clr_i) | set_i;
    end
  end

  assign q_o = bits_q;

endmodule

// File: rtl/rp_edge_rise.sv
module rp_edge_rise #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/rp_msi_match.sv
module rp_msi_match #(
  parameter int unsigned NUM_VEC = 32,
  parameter int unsigned MADDR_W = 32,
  parameter int unsigned MDATA_W = 32
) (
  input  logic               valid_i,
  input  logic [MADDR_W-1:0] addr_i,
  input  logic [MDATA_W-1:0] data_i,
  input  logic [MADDR_W-1:0] target_i,
  output logic [NUM_VEC-1:0] hit_o,
  output logic               addr_miss_o,
  output logic               range_miss_o
);

  logic addr_ok;
  logic in_range;

  assign addr_ok  = (addr_i == target_i);
  assign in_range = (data_i < MDATA_W'(NUM_VEC));

  // One comparator per vector gives a one-hot set pattern
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign hit_o[v] = valid_i && addr_ok && (data_i == MDATA_W'(v));
  end

  assign addr_miss_o  = valid_i && !addr_ok;
  assign range_miss_o = valid_i && addr_ok && !in_range;

endmodule

// File: rtl/rp_irq_collector.sv
module rp_irq_collector
  import rp_irq_pkg::*;
#(
  parameter int unsigned NUM_INTX = 4,
  parameter int unsigned NUM_VEC  = 32,
  parameter int unsigned REG_AW   = 8,
  parameter int unsigned DW       = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_INTX-1:0] intx_in,
  input  logic                msi_valid,
  input  logic [DW-1:0]       msi_addr,
  input  logic [DW-1:0]       msi_data,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                irq_out
);

  localparam int unsigned SRC_W = NUM_INTX + 1;

  // ---------------- register decode ----------------
  reg_sel_e sel;

  always_comb begin
    if (reg_addr == REG_AW'(OFF_SUMMARY))     sel = SEL_SUMMARY;
    else if (reg_addr == REG_AW'(OFF_MASK))   sel = SEL_MASK;
    else if (reg_addr == REG_AW'(OFF_VECTOR)) sel = SEL_VECTOR;
    else if (reg_addr == REG_AW'(OFF_TARGET)) sel = SEL_TARGET;
    else if (reg_addr == REG_AW'(OFF_ERROR))  sel = SEL_ERROR;
    else                                      sel = SEL_NONE;
  end

  logic wr_summary, wr_mask, wr_vector, wr_target, wr_error;

  assign wr_summary = reg_wr_en && (sel == SEL_SUMMARY);
  assign wr_mask    = reg_wr_en && (sel == SEL_MASK);
  assign wr_vector  = reg_wr_en && (sel == SEL_VECTOR);
  assign wr_target  = reg_wr_en && (sel == SEL_TARGET);
  assign wr_error   = reg_wr_en && (sel == SEL_ERROR);

  // ---------------- INTx path ----------------
  logic [NUM_INTX-1:0] intx_rise;
  logic [NUM_INTX-1:0] intx_clr;
  logic [NUM_INTX-1:0] intx_q;

  rp_edge_rise #(.W(NUM_INTX)) u_intx_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (intx_in),
    .rise_o (intx_rise)
  );

  assign intx_clr = wr_summary ? reg_wdata[INTX_LSB +: NUM_INTX] : '0;

  rp_sticky_bits #(.W(NUM_INTX)) u_intx_bits (
    .clk   (clk),
    .rst   (rst),
    .set_i (intx_rise),
    .clr_i (intx_clr),
    .q_o   (intx_q)
  );

  // ---------------- MSI path ----------------
  logic [DW-1:0]      target_q;
  logic [NUM_VEC-1:0] msi_hit;
  logic               addr_miss;
  logic               range_miss;
  logic [NUM_VEC-1:0] vec_clr;
  logic [NUM_VEC-1:0] vec_q;

  rp_msi_match #(
    .NUM_VEC (NUM_VEC),
    .MADDR_W (DW),
    .MDATA_W (DW)
  ) u_match (
    .valid_i      (msi_valid),
    .addr_i       (msi_addr),
    .data_i       (msi_data),
    .target_i     (target_q),
    .hit_o        (msi_hit),
    .addr_miss_o  (addr_miss),
    .range_miss_o (range_miss)
  );

  assign vec_clr = wr_vector ? reg_wdata[NUM_VEC-1:0] : '0;

  rp_sticky_bits #(.W(NUM_VEC)) u_vec_bits (
    .clk   (clk),
    .rst   (rst),
    .set_i (msi_hit),
    .clr_i (vec_clr),
    .q_o   (vec_q)
  );

  // Summary bit is re-asserted every cycle a vector is pending
  logic msi_sum_set;
  logic msi_sum_clr;
  logic msi_sum_q;

  assign msi_sum_set = (|vec_q) | (|msi_hit);
  assign msi_sum_clr = wr_summary && reg_wdata[MSI_SUM_BIT];

  rp_sticky_bits #(.W(1)) u_msi_sum (
    .clk   (clk),
    .rst   (rst),
    .set_i (msi_sum_set),
    .clr_i (msi_sum_clr),
    .q_o   (msi_sum_q)
  );

  // ---------------- error flags ----------------
  logic [ERR_W-1:0] err_set;
  logic [ERR_W-1:0] err_clr;
  logic [ERR_W-1:0] err_q;

  always_comb begin
    err_set                = '0;
    err_set[ERR_ADDR_BIT]  = addr_miss;
    err_set[ERR_RANGE_BIT] = range_miss;
  end

  assign err_clr = wr_error ? reg_wdata[ERR_W-1:0] : '0;

  rp_sticky_bits #(.W(ERR_W)) u_err_bits (
    .clk   (clk),
    .rst   (rst),
    .set_i (err_set),
    .clr_i (err_clr),
    .q_o   (err_q)
  );

  // ---------------- plain registers ----------------
  logic [SRC_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '1;
      target_q <= '0;
    end else begin
      if (wr_mask) begin
        mask_q <= {reg_wdata[MSI_SUM_BIT], reg_wdata[INTX_LSB +: NUM_INTX]};
      end
      if (wr_target) begin
        target_q <= reg_wdata;
      end
    end
  end

  // ---------------- interrupt output ----------------
  logic [SRC_W-1:0] src_bits;
  logic             irq_q;

  assign src_bits = {msi_sum_q, intx_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(src_bits & ~mask_q);
    end
  end

  assign irq_out = irq_q;

  // ---------------- read path ----------------
  logic [DW-1:0] summary_word;
  logic [DW-1:0] mask_word;
  logic [DW-1:0] read_mux;
  logic [DW-1:0] rdata_q;

  always_comb begin
    summary_word                         = '0;
    summary_word[INTX_LSB +: NUM_INTX]   = intx_q;
    summary_word[MSI_SUM_BIT]            = msi_sum_q;
    mask_word                            = '0;
    mask_word[INTX_LSB +: NUM_INTX]      = mask_q[NUM_INTX-1:0];
    mask_word[MSI_SUM_BIT]               = mask_q[NUM_INTX];
  end

  always_comb begin
    unique case (sel)
      SEL_SUMMARY: read_mux = summary_word;
      SEL_MASK:    read_mux = mask_word;
      SEL_VECTOR:  read_mux = DW'(vec_q);
      SEL_TARGET:  read_mux = target_q;
      SEL_ERROR:   read_mux = DW'(err_q);
      default:     read_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd_en) begin
      rdata_q <= read_mux;
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/rp_irq_collector_chk.sv
module rp_irq_collector_chk #(
  parameter int unsigned NUM_INTX = 4,
  parameter int unsigned NUM_VEC  = 32,
  parameter int unsigned REG_AW   = 8,
  parameter int unsigned DW       = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                msi_valid,
  input logic [DW-1:0]       msi_addr,
  input logic [DW-1:0]       msi_data,
  input logic                reg_wr_en,
  input logic [REG_AW-1:0]   reg_addr,
  input logic [DW-1:0]       reg_wdata,
  input logic                irq_out,
  input logic [NUM_INTX:0]   src_bits,
  input logic [NUM_INTX:0]   mask_bits,
  input logic [NUM_VEC-1:0]  vec_bits,
  input logic [DW-1:0]       target_bits,
  input logic [1:0]          err_bits
);

  localparam int unsigned IDX_W = $clog2(NUM_VEC);

  logic sum_clear_wr;
  assign sum_clear_wr = reg_wr_en && (reg_addr == REG_AW'(8'h00)) && reg_wdata[23];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (vec_bits == '0) && (src_bits == '0) && (err_bits == '0) && !irq_out);

  // R3
  msi_sets_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (msi_valid && (msi_addr == target_bits) && (msi_data < DW'(NUM_VEC)))
      |=> vec_bits[$past(msi_data[IDX_W-1:0])] && src_bits[NUM_INTX]);

  // R4
  addr_miss_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (msi_valid && (msi_addr != target_bits)) |=> err_bits[0]);

  // R6
  summary_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (src_bits[NUM_INTX] && !sum_clear_wr) |=> src_bits[NUM_INTX]);

  // R6
  pending_holds_summary_chk: assert property (@(posedge clk) disable iff (rst)
    (|vec_bits) |=> src_bits[NUM_INTX]);

  // R7
  irq_follows_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (|(src_bits & ~mask_bits)) |=> irq_out);

  // R7
  irq_quiet_when_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(src_bits & ~mask_bits)) |=> !irq_out);

endmodule

bind rp_irq_collector rp_irq_collector_chk #(
  .NUM_INTX (NUM_INTX),
  .NUM_VEC  (NUM_VEC),
  .REG_AW   (REG_AW),
  .DW       (DW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .msi_valid   (msi_valid),
  .msi_addr    (msi_addr),
  .msi_data    (msi_data),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .irq_out     (irq_out),
  .src_bits    ({msi_sum_q, intx_q}),
  .mask_bits   (mask_q),
  .vec_bits    (vec_q),
  .target_bits (target_q),
  .err_bits    (err_q)
);

// File: tb/rp_irq_collector_test.sv
module rp_irq_collector_test;

  localparam logic [7:0]  A_SUM = 8'h00;
  localparam logic [7:0]  A_MSK = 8'h04;
  localparam logic [7:0]  A_VEC = 8'h08;
  localparam logic [7:0]  A_TGT = 8'h0C;
  localparam logic [7:0]  A_ERR = 8'h10;
  localparam logic [31:0] TGT   = 32'hFEE0_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  intx_in = '0;
  logic        msi_valid = 1'b0;
  logic [31:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rp_irq_collector uut (
    .clk       (clk),
    .rst       (rst),
    .intx_in   (intx_in),
    .msi_valid (msi_valid),
    .msi_addr  (msi_addr),
    .msi_data  (msi_data),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    step();
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    reg_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic msi_send(input logic [31:0] a, input logic [31:0] d);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    step();
    msi_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    read_check("R1 summary", A_SUM, 32'h0);
    read_check("R1 mask", A_MSK, 32'h008F_0000);
    read_check("R1 vector", A_VEC, 32'h0);
    read_check("R1 target", A_TGT, 32'h0);
    read_check("R1 error", A_ERR, 32'h0);
  endtask

  task automatic t_regmap();
    reg_write(A_MSK, 32'hFFFF_FFFF);
    read_check("R9 mask reserved bits", A_MSK, 32'h008F_0000);
    read_check("R9 unmapped offset", 8'h1C, 32'h0);
    reg_write(A_TGT, TGT);
    read_check("R9 target readback", A_TGT, TGT);
    reg_write(A_MSK, 32'h0);
  endtask

  task automatic t_intx();
    intx_in[2] = 1'b1;
    step();
    intx_in[2] = 1'b0;
    read_check("R2 pulse sets bit 18", A_SUM, 32'h0004_0000);
    check("R7 irq on unmasked intx", {31'b0, irq_out}, 32'h1);
    reg_write(A_SUM, 32'h0000_0000);
    read_check("R2 write zero keeps bit", A_SUM, 32'h0004_0000);
    reg_write(A_SUM, 32'h0004_0000);
    read_check("R2 w1c clears", A_SUM, 32'h0);
    check("R7 irq drops", {31'b0, irq_out}, 32'h0);
    intx_in[0] = 1'b1;
    step();
    read_check("R2 level sets bit 16", A_SUM, 32'h0001_0000);
    reg_write(A_SUM, 32'h0001_0000);
    step();
    read_check("R2 held level no re-set", A_SUM, 32'h0);
    intx_in[0] = 1'b0;
    step();
  endtask

  task automatic t_msi();
    msi_send(TGT, 32'd5);
    read_check("R3 vector 5", A_VEC, 32'h0000_0020);
    read_check("R3 summary msi bit", A_SUM, 32'h0080_0000);
    msi_send(TGT, 32'd31);
    read_check("R3 vector 31", A_VEC, 32'h8000_0020);
    reg_write(A_VEC, 32'h0000_0020);
    read_check("R5 w1c one vector", A_VEC, 32'h8000_0000);
    reg_write(A_SUM, 32'h0080_0000);
    read_check("R6 clear ignored while pending", A_SUM, 32'h0080_0000);
    reg_write(A_VEC, 32'h8000_0000);
    read_check("R5 vectors empty", A_VEC, 32'h0);
    read_check("R6 summary sticky", A_SUM, 32'h0080_0000);
    reg_write(A_SUM, 32'h0080_0000);
    read_check("R6 summary cleared", A_SUM, 32'h0);
  endtask

  task automatic t_error();
    msi_send(32'hFEE0_2000, 32'd3);
    read_check("R4 addr miss no vector", A_VEC, 32'h0);
    read_check("R4 addr miss flag", A_ERR, 32'h1);
    msi_send(TGT, 32'd40);
    read_check("R4 range miss no vector", A_VEC, 32'h0);
    read_check("R4 range miss flag", A_ERR, 32'h3);
    reg_write(A_ERR, 32'h1);
    read_check("R10 clear addr flag", A_ERR, 32'h2);
    reg_write(A_ERR, 32'h2);
    read_check("R10 clear range flag", A_ERR, 32'h0);
    reg_write(A_SUM, 32'h008F_0000);
  endtask

  task automatic t_mask();
    intx_in[3] = 1'b1;
    step();
    intx_in[3] = 1'b0;
    reg_write(A_MSK, 32'h0008_0000);
    step();
    check("R7 masked intx no irq", {31'b0, irq_out}, 32'h0);
    reg_write(A_MSK, 32'h0);
    step();
    check("R7 unmasked intx irq", {31'b0, irq_out}, 32'h1);
    reg_write(A_SUM, 32'h0008_0000);
    reg_write(A_MSK, 32'h0080_0000);
    msi_send(TGT, 32'd0);
    step();
    check("R7 masked msi no irq", {31'b0, irq_out}, 32'h0);
    reg_write(A_MSK, 32'h0);
    step();
    check("R7 unmasked msi irq", {31'b0, irq_out}, 32'h1);
    reg_write(A_VEC, 32'hFFFF_FFFF);
    reg_write(A_SUM, 32'h008F_0000);
  endtask

  task automatic t_collide();
    intx_in[1] = 1'b1;
    step();
    intx_in[1] = 1'b0;
    step();
    // new rising edge and clear of the same bit in one cycle
    intx_in[1] = 1'b1;
    reg_write(A_SUM, 32'h0002_0000);
    read_check("R8 intx set beats clear", A_SUM, 32'h0002_0000);
    intx_in[1] = 1'b0;
    msi_send(TGT, 32'd3);
    msi_valid = 1'b1; msi_addr = TGT; msi_data = 32'd3;
    reg_write(A_VEC, 32'h0000_0008);
    msi_valid = 1'b0;
    read_check("R8 msi set beats clear", A_VEC, 32'h0000_0008);
    reg_write(A_VEC, 32'h0000_0008);
    read_check("R5 vector 3 cleared", A_VEC, 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    step();
    t_reset();
    t_regmap();
    t_intx();
    t_msi();
    t_error();
    t_mask();
    t_collide();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule